// File: doc/BRIEF.md
# Hungarian Assignment Solver

This block computes a minimum-cost assignment of `n` rows (tasks) to `m` columns (resources), with `n <= m`, using the potential-based Hungarian method. Every operand sits in one external single-port memory: the cost matrix, the row and column potentials, the per-column slack, the predecessor links, the used flags and the pairing result. The block drives an address, write data and a write strobe, and it receives read data one cycle after it presents an address. The cost matrix is only read.

A host loads the costs into memory, sets the row and column counts and pulses `start_i`. The solver clears its working arrays and processes the rows one at a time. For each row it grows an alternating path by repeated slack scans and potential updates until it reaches a free column, then it walks the predecessor links back to flip the pairing. At the end it raises `done_o` for one cycle. The pairing array then holds, for each column, the row assigned to it, and slot 0 of the column-potential array holds the negated total cost. A request with more rows than columns is rejected at once with `err_o`.

Top module: `hung_assign_solver`

## Requirements
- R1: After reset the block is idle, `done_o` and `err_o` are low and no memory write occurs until `start_i` is sampled high.
- R2: A start with `n <= m` completes by itself and signals completion with `done_o` high for exactly one cycle, with `err_o` low.
- R3: Afterwards, for every column j in 1..m the pairing word holds the row paired to column j, or 0 if the column is free, and each row 1..n appears in exactly one column.
- R4: The sum of cost[row][col] over the reported pairs equals the smallest total cost over all valid assignments.
- R5: Slot 0 of the column-potential region holds the negated minimum total cost as a two's-complement data word.
- R6: The cost region is never written, and its contents after a run equal those before.
- R7: If `n > m` when start is sampled, `done_o` rises in the next cycle with `err_o` high and no memory write takes place. `err_o` holds until the next accepted start clears it.
- R8: The memory address is {region[2:0], hi[IDX_W-1:0], lo[IDX_W-1:0]}. The region codes are: cost 0, row potential 1, column potential 2, pairing 3, predecessor 4, slack 5, used flag 6. A cost entry uses hi = row (1..n) and lo = column (1..m). The other regions use hi = 0 and lo = index 0..m. Writes go only to regions 1..6 with hi = 0 and lo <= m.
- R9: Read data is taken as the word at the address presented in the previous cycle. Results are correct with a memory of that latency.
- R10: A start pulse that arrives while a run is in progress is ignored: the run yields correct results and exactly one `done_o` pulse.
- R11: Asserting reset during a run returns the block to idle at once, with no write and `done_o` low, and a following run gives correct results.
- R12: Non-negative costs up to 4095 are handled, including matrices in which most entries share one large "no route" value, with no overflow of potentials or slacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| start_i | input | 1 | Begin pulse, sampled in idle |
| n_rows_i | input | IDX_W | Number of rows n |
| n_cols_i | input | IDX_W | Number of columns m |
| done_o | output | 1 | One-cycle end pulse |
| err_o | output | 1 | Set when the request had n > m |
| mem_addr_o | output | 3+2*IDX_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle latency |

## Verification
Small random matrices with costs from 0 to 29 test the optimum against an exhaustive search over all assignments. Matrices dominated by a large "unavailable" value, and wide-range costs up to 4095, test the signed potential arithmetic and the infinity handling. A directed matrix on which a row-by-row greedy choice is suboptimal separates a true optimum from a greedy one. All-equal and zero-antidiagonal matrices test ties, single-row and square shapes test the loop bounds, and an over-tall request, a start while busy and a reset mid-run test the control paths.

// File: rtl/hasg_pkg.sv
package hasg_pkg;

    // Controller states: each memory read is split into an address state
    // and a following state that consumes the returned word.
    typedef enum logic [5:0] {
        ST_IDLE,
        ST_INIT_U, ST_INIT_V, ST_INIT_P, ST_INIT_W,
        ST_ROW_P0, ST_CLR_T, ST_CLR_L,
        ST_MARK, ST_RD_P0, ST_GOT_P0, ST_RD_U, ST_GOT_U,
        ST_SC_T, ST_SC_TA, ST_SC_AV, ST_SC_VL, ST_SC_LC,
        ST_SC_WL, ST_SC_WW, ST_SC_CMP, ST_SC_NX,
        ST_UP_T, ST_UP_TG, ST_UP_P, ST_UP_VG, ST_UP_VW,
        ST_UP_UR, ST_UP_UG, ST_UP_UW,
        ST_UP_LR, ST_UP_LG, ST_UP_LW, ST_UP_NX,
        ST_END_RD, ST_END_G,
        ST_AUG_RW, ST_AUG_GW, ST_AUG_RP, ST_AUG_GP, ST_AUG_WP,
        ST_ROW_NX, ST_DONE
    } state_t;

    // Memory regions, carried in the top three address bits.
    typedef enum logic [2:0] {
        RG_COST  = 3'd0,
        RG_UPOT  = 3'd1,
        RG_VPOT  = 3'd2,
        RG_PAIR  = 3'd3,
        RG_PRED  = 3'd4,
        RG_SLACK = 3'd5,
        RG_USED  = 3'd6
    } region_t;

    localparam int REGION_W = 3;

    // Largest positive value of a signed word, used as "infinity".
    function automatic int unsigned inf_mag(input int unsigned width);
        return (32'd1 << (width - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/hasg_seq.sv
module hasg_seq
    import hasg_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [IDX_W-1:0]         n_i,
    input  logic [IDX_W-1:0]         m_i,
    input  logic signed [DATA_W-1:0] rdata_i,
    output state_t                   st_o,
    output logic [IDX_W-1:0]         m_o,
    output logic [IDX_W-1:0]         i_o,
    output logic [IDX_W-1:0]         j_o,
    output logic [IDX_W-1:0]         j0_o,
    output logic [IDX_W-1:0]         j1_o,
    output logic [IDX_W-1:0]         i0_o,
    output logic [IDX_W-1:0]         pj_o,
    output logic [IDX_W-1:0]         jw_o,
    output logic signed [DATA_W-1:0] cur_o,
    output logic signed [DATA_W-1:0] tmp_o,
    output logic                     err_o
);
    localparam logic signed [DATA_W-1:0] INF = DATA_W'(inf_mag(DATA_W));

    state_t                   st;
    logic [IDX_W-1:0]         n_q, m_q, i_q, j_q, j0_q, j1_q, i0_q, pj_q, jw_q;
    logic signed [DATA_W-1:0] ui0_q, cur_q, lj_q, delta_q, tmp_q;
    logic                     err_q;
    logic [IDX_W-1:0]         rd_idx;
    logic                     rd_nz;

    assign rd_idx = rdata_i[IDX_W-1:0];
    assign rd_nz  = (rdata_i != '0);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st <= ST_IDLE;
            n_q <= '0; m_q <= '0; i_q <= '0; j_q <= '0;
            j0_q <= '0; j1_q <= '0; i0_q <= '0; pj_q <= '0; jw_q <= '0;
            ui0_q <= '0; cur_q <= '0; lj_q <= '0; delta_q <= '0; tmp_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start_i) begin
                    if (n_i > m_i) begin
                        err_q <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        err_q <= 1'b0;
                        n_q   <= n_i;
                        m_q   <= m_i;
                        j_q   <= '0;
                        st    <= ST_INIT_U;
                    end
                end
                // clear potentials, pairing and predecessors over 0..m
                ST_INIT_U: st <= ST_INIT_V;
                ST_INIT_V: st <= ST_INIT_P;
                ST_INIT_P: st <= ST_INIT_W;
                ST_INIT_W: begin
                    if (j_q == m_q) begin
                        if (n_q == '0) st <= ST_DONE;
                        else begin
                            i_q <= IDX_W'(1);
                            st  <= ST_ROW_P0;
                        end
                    end else begin
                        j_q <= j_q + 1'b1;
                        st  <= ST_INIT_U;
                    end
                end
                // per-row setup: control slot gets the row, flags and slacks reset
                ST_ROW_P0: begin
                    j_q <= IDX_W'(1);
                    st  <= ST_CLR_T;
                end
                ST_CLR_T: st <= ST_CLR_L;
                ST_CLR_L: begin
                    if (j_q == m_q) begin
                        j0_q <= '0;
                        st   <= ST_MARK;
                    end else begin
                        j_q <= j_q + 1'b1;
                        st  <= ST_CLR_T;
                    end
                end
                // one step of path growth
                ST_MARK:   st <= ST_RD_P0;
                ST_RD_P0:  st <= ST_GOT_P0;
                ST_GOT_P0: begin
                    i0_q <= rd_idx;
                    st   <= ST_RD_U;
                end
                ST_RD_U:   st <= ST_GOT_U;
                ST_GOT_U: begin
                    ui0_q   <= rdata_i;
                    delta_q <= INF;
                    j1_q    <= '0;
                    j_q     <= IDX_W'(1);
                    st      <= ST_SC_T;
                end
                // slack scan over unused columns
                ST_SC_T:  st <= ST_SC_TA;
                ST_SC_TA: st <= rd_nz ? ST_SC_NX : ST_SC_AV;
                ST_SC_AV: begin
                    cur_q <= rdata_i - ui0_q;
                    st    <= ST_SC_VL;
                end
                ST_SC_VL: begin
                    cur_q <= cur_q - rdata_i;
                    st    <= ST_SC_LC;
                end
                ST_SC_LC: begin
                    if (cur_q < rdata_i) begin
                        lj_q <= cur_q;
                        st   <= ST_SC_WL;
                    end else begin
                        lj_q <= rdata_i;
                        st   <= ST_SC_CMP;
                    end
                end
                ST_SC_WL: st <= ST_SC_WW;
                ST_SC_WW: st <= ST_SC_CMP;
                ST_SC_CMP: begin
                    if (lj_q < delta_q) begin
                        delta_q <= lj_q;
                        j1_q    <= j_q;
                    end
                    st <= ST_SC_NX;
                end
                ST_SC_NX: begin
                    if (j_q == m_q) begin
                        j_q <= '0;
                        st  <= ST_UP_T;
                    end else begin
                        j_q <= j_q + 1'b1;
                        st  <= ST_SC_T;
                    end
                end
                // potential / slack update over 0..m
                ST_UP_T:  st <= ST_UP_TG;
                ST_UP_TG: st <= rd_nz ? ST_UP_P : ST_UP_LR;
                ST_UP_P: begin
                    pj_q <= rd_idx;
                    st   <= ST_UP_VG;
                end
                ST_UP_VG: begin
                    tmp_q <= rdata_i - delta_q;
                    st    <= ST_UP_VW;
                end
                ST_UP_VW: st <= ST_UP_UR;
                ST_UP_UR: st <= ST_UP_UG;
                ST_UP_UG: begin
                    tmp_q <= rdata_i + delta_q;
                    st    <= ST_UP_UW;
                end
                ST_UP_UW: st <= ST_UP_NX;
                ST_UP_LR: st <= ST_UP_LG;
                ST_UP_LG: begin
                    tmp_q <= rdata_i - delta_q;
                    st    <= ST_UP_LW;
                end
                ST_UP_LW: st <= ST_UP_NX;
                ST_UP_NX: begin
                    if (j_q == m_q) begin
                        j0_q <= j1_q;
                        st   <= ST_END_RD;
                    end else begin
                        j_q <= j_q + 1'b1;
                        st  <= ST_UP_T;
                    end
                end
                ST_END_RD: st <= ST_END_G;
                ST_END_G:  st <= rd_nz ? ST_MARK : ST_AUG_RW;
                // walk predecessor links back and shift the pairing
                ST_AUG_RW: st <= ST_AUG_GW;
                ST_AUG_GW: begin
                    jw_q <= rd_idx;
                    st   <= ST_AUG_RP;
                end
                ST_AUG_RP: st <= ST_AUG_GP;
                ST_AUG_GP: begin
                    tmp_q <= rdata_i;
                    st    <= ST_AUG_WP;
                end
                ST_AUG_WP: begin
                    j0_q <= jw_q;
                    st   <= (jw_q == '0) ? ST_ROW_NX : ST_AUG_RW;
                end
                ST_ROW_NX: begin
                    if (i_q == n_q) st <= ST_DONE;
                    else begin
                        i_q <= i_q + 1'b1;
                        st  <= ST_ROW_P0;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign st_o  = st;
    assign m_o   = m_q;
    assign i_o   = i_q;
    assign j_o   = j_q;
    assign j0_o  = j0_q;
    assign j1_o  = j1_q;
    assign i0_o  = i0_q;
    assign pj_o  = pj_q;
    assign jw_o  = jw_q;
    assign cur_o = cur_q;
    assign tmp_o = tmp_q;
    assign err_o = err_q;

endmodule

// File: rtl/hasg_port.sv
module hasg_port
    import hasg_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    localparam int ADDR_W = REGION_W + 2 * IDX_W
) (
    input  state_t                   st_i,
    input  logic [IDX_W-1:0]         i_i,
    input  logic [IDX_W-1:0]         j_i,
    input  logic [IDX_W-1:0]         j0_i,
    input  logic [IDX_W-1:0]         j1_i,
    input  logic [IDX_W-1:0]         i0_i,
    input  logic [IDX_W-1:0]         pj_i,
    input  logic [IDX_W-1:0]         jw_i,
    input  logic signed [DATA_W-1:0] cur_i,
    input  logic signed [DATA_W-1:0] tmp_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic signed [DATA_W-1:0] wdata_o,
    output logic                     we_o
);
    localparam logic signed [DATA_W-1:0] INF = DATA_W'(inf_mag(DATA_W));

    region_t          rg;
    logic [IDX_W-1:0] hi, lo;

    // Moore decode: address, data and strobe from state and registers only
    always_comb begin
        rg      = RG_COST;
        hi      = '0;
        lo      = '0;
        wdata_o = '0;
        we_o    = 1'b0;
        unique case (st_i)
            ST_INIT_U: begin rg = RG_UPOT;  lo = j_i; we_o = 1'b1; end
            ST_INIT_V: begin rg = RG_VPOT;  lo = j_i; we_o = 1'b1; end
            ST_INIT_P: begin rg = RG_PAIR;  lo = j_i; we_o = 1'b1; end
            ST_INIT_W: begin rg = RG_PRED;  lo = j_i; we_o = 1'b1; end
            ST_ROW_P0: begin rg = RG_PAIR;  wdata_o = DATA_W'(i_i); we_o = 1'b1; end
            ST_CLR_T:  begin rg = RG_USED;  lo = j_i; we_o = 1'b1; end
            ST_CLR_L:  begin rg = RG_SLACK; lo = j_i; wdata_o = INF; we_o = 1'b1; end
            ST_MARK:   begin rg = RG_USED;  lo = j0_i; wdata_o = DATA_W'(1); we_o = 1'b1; end
            ST_RD_P0:  begin rg = RG_PAIR;  lo = j0_i; end
            ST_RD_U:   begin rg = RG_UPOT;  lo = i0_i; end
            ST_SC_T:   begin rg = RG_USED;  lo = j_i; end
            ST_SC_TA:  begin rg = RG_COST;  hi = i0_i; lo = j_i; end
            ST_SC_AV:  begin rg = RG_VPOT;  lo = j_i; end
            ST_SC_VL:  begin rg = RG_SLACK; lo = j_i; end
            ST_SC_WL:  begin rg = RG_SLACK; lo = j_i; wdata_o = cur_i; we_o = 1'b1; end
            ST_SC_WW:  begin rg = RG_PRED;  lo = j_i; wdata_o = DATA_W'(j0_i); we_o = 1'b1; end
            ST_UP_T:   begin rg = RG_USED;  lo = j_i; end
            ST_UP_TG:  begin rg = RG_PAIR;  lo = j_i; end
            ST_UP_P:   begin rg = RG_VPOT;  lo = j_i; end
            ST_UP_VW:  begin rg = RG_VPOT;  lo = j_i; wdata_o = tmp_i; we_o = 1'b1; end
            ST_UP_UR:  begin rg = RG_UPOT;  lo = pj_i; end
            ST_UP_UW:  begin rg = RG_UPOT;  lo = pj_i; wdata_o = tmp_i; we_o = 1'b1; end
            ST_UP_LR:  begin rg = RG_SLACK; lo = j_i; end
            ST_UP_LW:  begin rg = RG_SLACK; lo = j_i; wdata_o = tmp_i; we_o = 1'b1; end
            ST_END_RD: begin rg = RG_PAIR;  lo = j0_i; end
            ST_AUG_RW: begin rg = RG_PRED;  lo = j0_i; end
            ST_AUG_RP: begin rg = RG_PAIR;  lo = jw_i; end
            ST_AUG_WP: begin rg = RG_PAIR;  lo = j0_i; wdata_o = tmp_i; we_o = 1'b1; end
            default: ;
        endcase
    end

    assign addr_o = {rg, hi, lo};

    logic unused_j1;
    assign unused_j1 = ^j1_i;

endmodule

// File: rtl/hung_assign_solver.sv
module hung_assign_solver
    import hasg_pkg::*;
#(
    parameter int MAX_DIM = 7,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(MAX_DIM + 1),
    localparam int ADDR_W = REGION_W + 2 * IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [IDX_W-1:0]         n_rows_i,
    input  logic [IDX_W-1:0]         n_cols_i,
    output logic                     done_o,
    output logic                     err_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic signed [DATA_W-1:0] mem_wdata_o,
    output logic                     mem_we_o,
    input  logic signed [DATA_W-1:0] mem_rdata_i
);
    state_t                   state;
    logic [IDX_W-1:0]         m_q, i_q, j_q, j0_q, j1_q, i0_q, pj_q, jw_q;
    logic signed [DATA_W-1:0] cur_q, tmp_q;

    hasg_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .n_i     (n_rows_i),
        .m_i     (n_cols_i),
        .rdata_i (mem_rdata_i),
        .st_o    (state),
        .m_o     (m_q),
        .i_o     (i_q),
        .j_o     (j_q),
        .j0_o    (j0_q),
        .j1_o    (j1_q),
        .i0_o    (i0_q),
        .pj_o    (pj_q),
        .jw_o    (jw_q),
        .cur_o   (cur_q),
        .tmp_o   (tmp_q),
        .err_o   (err_o)
    );

    hasg_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_port (
        .st_i    (state),
        .i_i     (i_q),
        .j_i     (j_q),
        .j0_i    (j0_q),
        .j1_i    (j1_q),
        .i0_i    (i0_q),
        .pj_i    (pj_q),
        .jw_i    (jw_q),
        .cur_i   (cur_q),
        .tmp_i   (tmp_q),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o),
        .we_o    (mem_we_o)
    );

    assign done_o = (state == ST_DONE);

endmodule

// File: rtl/hasg_checker.sv
module hasg_checker
    import hasg_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic              err_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input state_t            state,
    input logic [IDX_W-1:0]  j_q,
    input logic [IDX_W-1:0]  m_q
);
    logic [REGION_W-1:0] wr_region;
    assign wr_region = mem_addr_o[ADDR_W-1 -: REGION_W];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !mem_we_o);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_cost_ro_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (wr_region != REGION_W'(RG_COST)));

    assert_reject_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> $past(start_i));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> done_o);

    assert_region_valid_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (wr_region != {REGION_W{1'b1}}));

    assert_col_range_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_DONE) |-> (j_q <= m_q));

endmodule

bind hung_assign_solver hasg_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .done_o     (done_o),
    .err_o      (err_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .state      (state),
    .j_q        (j_q),
    .m_q        (m_q)
);

// File: tb/hung_assign_solver_bench.sv
module hung_assign_solver_bench;

    localparam int IW = 3;
    localparam int DW = 16;
    localparam int AW = 9;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic [IW-1:0]        n_rows_i = '0;
    logic [IW-1:0]        n_cols_i = '0;
    logic                 done_o, err_o, mem_we_o;
    logic [AW-1:0]        mem_addr_o;
    logic signed [DW-1:0] mem_wdata_o;
    logic signed [DW-1:0] mem_rdata_i;

    always #10 clk = ~clk;  // 50 MHz

    hung_assign_solver u_hung_assign_solver (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .n_rows_i    (n_rows_i),
        .n_cols_i    (n_cols_i),
        .done_o      (done_o),
        .err_o       (err_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // single-port memory with one cycle read latency (R9)
    logic signed [DW-1:0] mem [0:511];
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o];
    end

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    int bad_wr  = 0;
    int done_cnt = 0;
    int cur_m   = 0;
    int cost [1:7][1:7];

    always @(posedge clk) begin
        if (!rst && mem_we_o) begin
            wr_cnt++;
            // R8 / R6: legal region, hi = 0, lo <= m
            if (mem_addr_o[8:6] == 3'd0 || mem_addr_o[8:6] == 3'd7 ||
                mem_addr_o[5:3] != 3'd0 || int'(mem_addr_o[2:0]) > cur_m)
                bad_wr++;
        end
        if (!rst && done_o) done_cnt++;
    end

    function automatic int addr_of(int rg, int hi, int lo);
        return rg * 64 + hi * 8 + lo;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // exhaustive minimum over all injective row->column maps
    function automatic int brute(int n, int m);
        int best = 32'h7fffffff;
        int total = 1;
        for (int k = 0; k < n; k++) total *= m;
        for (int code = 0; code < total; code++) begin
            int c = code;
            int used = 0;
            int s = 0;
            bit ok = 1'b1;
            for (int r = 1; r <= n; r++) begin
                int col = (c % m) + 1;
                c = c / m;
                if (used[col]) ok = 1'b0;
                used[col] = 1'b1;
                s += cost[r][col];
            end
            if (ok && s < best) best = s;
        end
        return best;
    endfunction

    task automatic load(int n, int m);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                mem[addr_of(0, r, c)] = (r >= 1 && r <= n && c >= 1 && c <= m) ?
                    DW'(cost[r][c]) : DW'(16'h0bad);
        for (int rg = 1; rg < 8; rg++)
            for (int k = 0; k < 64; k++)
                mem[rg * 64 + k] = DW'($urandom % 3000);
    endtask

    task automatic pulse_start(int n, int m);
        @(negedge clk);
        n_rows_i = IW'(n);
        n_cols_i = IW'(m);
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic check_results(int n, int m, string tag);
        int exp_cost = brute(n, m);
        int got_cost = 0;
        int seen = 0;
        bit valid = 1'b1;
        int a_ok = 1;
        for (int c = 1; c <= m; c++) begin
            int r = int'(mem[addr_of(3, 0, c)]);
            if (r < 0 || r > n) valid = 1'b0;
            else if (r != 0) begin
                if (seen[r]) valid = 1'b0;
                seen[r] = 1'b1;
                got_cost += cost[r][c];
            end
        end
        for (int r = 1; r <= n; r++) if (!seen[r]) valid = 1'b0;
        chk(valid, "R3", {tag, " pairing valid"}, int'(valid), 1);
        chk(valid && got_cost == exp_cost, "R4", {tag, " assignment cost"}, got_cost, exp_cost);
        chk(int'(mem[addr_of(2, 0, 0)]) == -exp_cost, "R5", {tag, " negated cost"},
            int'(mem[addr_of(2, 0, 0)]), -exp_cost);
        for (int r = 1; r <= n; r++)
            for (int c = 1; c <= m; c++)
                if (int'(mem[addr_of(0, r, c)]) != cost[r][c]) a_ok = 0;
        chk(a_ok == 1, "R6", {tag, " cost region intact"}, a_ok, 1);
        chk(bad_wr == 0, "R8", {tag, " write addresses legal"}, bad_wr, 0);
    endtask

    task automatic run_case(int n, int m, string tag, bit busy_start);
        int cnt = 0;
        int d0;
        cur_m = m;
        load(n, m);
        bad_wr = 0;
        d0 = done_cnt;
        pulse_start(n, m);
        while (!done_o && cnt < 30000) begin
            @(negedge clk);
            cnt++;
            if (busy_start && cnt == 40) start_i = 1'b1;
            if (busy_start && cnt == 41) start_i = 1'b0;
        end
        chk(done_o == 1'b1, "R2", {tag, " completion seen"}, int'(done_o), 1);
        chk(err_o == 1'b0, "R2", {tag, " err low on valid run"}, int'(err_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R2", {tag, " done is one cycle"}, int'(done_o), 0);
        if (busy_start) begin
            repeat (30) @(negedge clk);
            chk(done_cnt - d0 == 1, "R10", {tag, " single done"}, done_cnt - d0, 1);
        end
        check_results(n, m, tag);
    endtask

    task automatic fill_random(int n, int m, int style);
        for (int r = 1; r <= n; r++)
            for (int c = 1; c <= m; c++)
                case (style)
                    0: cost[r][c] = int'($urandom % 30);
                    1: cost[r][c] = ($urandom % 3 == 0) ? int'($urandom % 6) : 7;
                    default: cost[r][c] = int'($urandom % 4096);
                endcase
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done_o && !err_o && !mem_we_o, "R1", "idle after reset",
                int'({done_o, err_o, mem_we_o}), 0);
        end

        // greedy trap (R4): greedy gives 1+50, optimum 2+1
        cost[1][1] = 1; cost[1][2] = 2;  cost[1][3] = 50;
        cost[2][1] = 1; cost[2][2] = 50; cost[2][3] = 50;
        run_case(2, 3, "greedy trap", 1'b0);

        // single row
        for (int c = 1; c <= 6; c++) cost[1][c] = 20 - 3 * c;
        run_case(1, 6, "single row", 1'b0);

        // all equal, ties
        for (int r = 1; r <= 5; r++) for (int c = 1; c <= 6; c++) cost[r][c] = 7;
        run_case(5, 6, "all equal", 1'b0);

        // square with zero anti-diagonal
        for (int r = 1; r <= 5; r++)
            for (int c = 1; c <= 5; c++) cost[r][c] = (r + c == 6) ? 0 : 9;
        run_case(5, 5, "antidiagonal", 1'b0);

        // R7: rejection of n > m
        for (int r = 1; r <= 4; r++) for (int c = 1; c <= 3; c++) cost[r][c] = r + c;
        cur_m = 3;
        load(4, 3);
        wr_cnt = 0;
        pulse_start(4, 3);
        chk(done_o && err_o, "R7", "reject done+err next cycle",
            int'({done_o, err_o}), 3);
        @(negedge clk);
        chk(!done_o && err_o, "R7", "err held after done",
            int'({done_o, err_o}), 1);
        chk(wr_cnt == 0, "R7", "no writes on reject", wr_cnt, 0);

        // busy start ignored (R10), also clears err (R7 via R2 err-low check)
        fill_random(4, 6, 0);
        run_case(4, 6, "R10 busy start", 1'b1);

        // R11: reset mid-run
        fill_random(5, 6, 0);
        cur_m = 6;
        load(5, 6);
        pulse_start(5, 6);
        repeat (60) @(negedge clk);
        rst = 1'b1;
        #1;
        chk(!done_o && !mem_we_o, "R11", "reset mid-run quiet",
            int'({done_o, mem_we_o}), 0);
        @(negedge clk);
        rst = 1'b0;
        run_case(5, 6, "R11 after reset", 1'b0);

        // random patterns: small costs, sparse "no route", wide range (R12)
        for (int t = 0; t < 36; t++) begin
            int n = 1 + int'($urandom % 5);
            int m = n + int'($urandom % (7 - n));
            if (m > 6) m = 6;
            fill_random(n, m, t % 3);
            run_case(n, m, (t % 3 == 2) ? "R12 wide" :
                           (t % 3 == 1) ? "R12 sparse" : "random", 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule